// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one host request into the raw bus cycles a NAND flash device expects. The host gives an operation code, a row (page) address and a column address, and pulses a start strobe. The sequencer then works through a short step list for that operation. A step can be a command-latch cycle, an address-latch cycle, a wait on the device's ready/busy line, a fixed wait, a data-phase handshake with an external data mover, or one or more byte reads from the flash bus. Each latch cycle takes one clock.

Each operation has its own address shape. Page read and page program send two zero column bytes and three row bytes. Block erase sends only the three row bytes. Random data-out sends only the two column bytes. Read ID sends one zero byte, and it always starts with a device reset and a wait for ready. Program and erase end with a status read. Bit 0 of that byte is returned to the host as a pass/fail flag. The ready/busy input passes through a two-flop synchronizer. Every ready wait ignores that input for a short guard window, so the device has time to pull the line low.

Top module: `nand_cmd_seq`

## Requirements
- R1: When idle, a req_valid pulse starts an operation and busy is high from the next cycle. The operation codes are 0 page read, 1 page program, 2 block erase, 3 random data-out, 4 read status, 5 read ID, 6 reset. At the end, done is high for exactly one cycle, and busy is low in that same cycle. After reset, busy, done, fail and rd_valid are low and ce_n, we_n and re_n are high.
- R2: A req_valid pulse while busy is high is ignored. It adds no bus cycles and no extra done pulse.
- R3: Page read issues command 00h, address 00h, 00h, then row bits 7:0, 15:8 and 23:16, then command 30h, then waits for ready.
- R4: Page program issues 80h and the same five address bytes. It then requests a write transfer (xfer_wr=1) and holds until xfer_done. It then issues 10h, waits for ready, issues 70h and reads one status byte.
- R5: Block erase issues 60h, the three row bytes with no column bytes, D0h, waits for ready, then issues 70h and reads one status byte.
- R6: Random data-out issues 05h, column bits 7:0 then 15:8, and E0h. It waits for ready, then requests a read transfer (xfer_wr=0).
- R7: Read status issues 70h. The first byte read strobe (re_n low) comes STAT_DLY+1 cycles after that command strobe. The byte is returned on rd_data with rd_valid one cycle after its strobe.
- R8: Read ID issues FFh, waits for ready, then issues 90h and one address byte 00h. The first read strobe comes ID_DLY+1 cycles after that address strobe. Then ID_BYTES bytes are read on consecutive cycles and each one is returned on rd_data.
- R9: For program and erase, fail at the done pulse equals bit 0 of the status byte. For every other operation, fail is 0.
- R10: A ready wait does not finish while the synchronized ready/busy line is low. Every operation except reset and read ID waits for ready before its first latch cycle.
- R11: At most one of cle and ale is high during a latch cycle (we_n low). ce_n is low for the whole operation. While idle, ce_n, we_n and re_n are all high.
- R12: Reset issues command FFh and then waits for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start pulse for a request |
| req_op | input | 3 | Operation code |
| req_row | input | ROW_W | Row (page) address |
| req_col | input | COL_W | Column address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Status bit 0 of program/erase, valid with done |
| rd_valid | output | 1 | rd_data holds a byte read from the flash |
| rd_data | output | 8 | Byte read from the flash |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Bus byte driven during latch cycles |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Bus byte from the flash |
| rb_n | input | 1 | Ready/busy from the flash, low while busy |
| xfer_req | output | 1 | Data phase request to the data mover |
| xfer_wr | output | 1 | Data phase direction, 1 toward the flash |
| xfer_done | input | 1 | Data mover finished the data phase |

## Verification
The hardest case to reach is a ready wait that must stall. The device model drops ready/busy one clock after each confirm or reset command, and the synchronizer adds two more cycles of delay. A guard window that is too short would let the sequence go on early, and that only shows up as bytes in the wrong order. To expose it, the bench holds the line low across a whole request and watches that no latch cycle appears. It also gives each confirm command a long model busy time. The ignored start is reached by pulsing req_valid with a different operation in the middle of a page read. The scoreboard then has to see the page read's event list with nothing extra in it.

// File: rtl/nand_seq_pkg.sv
// Shared step encoding for the NAND command sequencer.
// Assumes operation codes 0..6 as listed in the brief.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        K_CMD  = 3'd0,
        K_ADDR = 3'd1,
        K_WAIT = 3'd2,
        K_DLY  = 3'd3,
        K_XFER = 3'd4,
        K_READ = 3'd5,
        K_END  = 3'd6
    } step_kind_e;

    typedef struct packed {
        step_kind_e  kind;
        logic [3:0]  arg;
    } step_t;

    localparam logic [2:0] OP_PAGE_RD = 3'd0;
    localparam logic [2:0] OP_PAGE_PG = 3'd1;
    localparam logic [2:0] OP_BLK_ER  = 3'd2;
    localparam logic [2:0] OP_COL_RD  = 3'd3;
    localparam logic [2:0] OP_STAT    = 3'd4;
    localparam logic [2:0] OP_READ_ID = 3'd5;
    localparam logic [2:0] OP_RESET   = 3'd6;

    // command selectors (arg of K_CMD)
    localparam logic [3:0] C_RD1 = 4'd0;
    localparam logic [3:0] C_RD2 = 4'd1;
    localparam logic [3:0] C_PG1 = 4'd2;
    localparam logic [3:0] C_PG2 = 4'd3;
    localparam logic [3:0] C_ER1 = 4'd4;
    localparam logic [3:0] C_ER2 = 4'd5;
    localparam logic [3:0] C_DO1 = 4'd6;
    localparam logic [3:0] C_DO2 = 4'd7;
    localparam logic [3:0] C_ST  = 4'd8;
    localparam logic [3:0] C_ID  = 4'd9;
    localparam logic [3:0] C_RST = 4'd10;

    // address byte selectors (arg of K_ADDR)
    localparam logic [3:0] A_ZERO = 4'd0;
    localparam logic [3:0] A_COL0 = 4'd1;
    localparam logic [3:0] A_COL1 = 4'd2;
    localparam logic [3:0] A_ROW0 = 4'd3;
    localparam logic [3:0] A_ROW1 = 4'd4;
    localparam logic [3:0] A_ROW2 = 4'd5;

    function automatic step_t mk(input step_kind_e k, input logic [3:0] a);
        step_t s;
        s.kind = k;
        s.arg  = a;
        return s;
    endfunction

endpackage

// File: rtl/nand_rb_sync.sv
// Two-flop synchronizer for the flash ready/busy line.
// Resets to "ready" so an idle bus reads as not busy.
module nand_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n,
    output logic rdy_s
);
    logic [1:0] sync_q;

    // shift the asynchronous line through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rb_n};
    end

    assign rdy_s = sync_q[1];
endmodule

// File: rtl/nand_step_timer.sv
// Saturating cycle counter that measures time spent in one step.
// Cleared whenever the sequencer advances or is idle.
module nand_step_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    // count up, stop at all ones
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   count <= '0;
        else if (~&count)    count <= count + 1'b1;
    end
endmodule

// File: rtl/nand_step_dec.sv
// Step list decoder: gives the step at position idx for operation op.
// Unknown operation codes end at once.
module nand_step_dec
    import nand_seq_pkg::*;
(
    input  logic [2:0] op,
    input  logic [3:0] idx,
    output step_t      step
);
    // select the step from the operation's fixed list
    always_comb begin
        step = mk(K_END, 4'd0);
        unique case (op)
            OP_PAGE_RD, OP_PAGE_PG: begin
                case (idx)
                    4'd0:  step = mk(K_WAIT, 4'd0);
                    4'd1:  step = mk(K_CMD, (op == OP_PAGE_RD) ? C_RD1 : C_PG1);
                    4'd2:  step = mk(K_ADDR, A_ZERO);
                    4'd3:  step = mk(K_ADDR, A_ZERO);
                    4'd4:  step = mk(K_ADDR, A_ROW0);
                    4'd5:  step = mk(K_ADDR, A_ROW1);
                    4'd6:  step = mk(K_ADDR, A_ROW2);
                    4'd7:  step = (op == OP_PAGE_RD) ? mk(K_CMD, C_RD2) : mk(K_XFER, 4'd1);
                    4'd8:  step = (op == OP_PAGE_RD) ? mk(K_WAIT, 4'd0) : mk(K_CMD, C_PG2);
                    4'd9:  step = (op == OP_PAGE_RD) ? mk(K_END, 4'd0) : mk(K_WAIT, 4'd0);
                    4'd10: step = mk(K_CMD, C_ST);
                    4'd11: step = mk(K_DLY, 4'd0);
                    4'd12: step = mk(K_READ, 4'd0);
                    default: step = mk(K_END, 4'd0);
                endcase
            end
            OP_BLK_ER: begin
                case (idx)
                    4'd0: step = mk(K_WAIT, 4'd0);
                    4'd1: step = mk(K_CMD, C_ER1);
                    4'd2: step = mk(K_ADDR, A_ROW0);
                    4'd3: step = mk(K_ADDR, A_ROW1);
                    4'd4: step = mk(K_ADDR, A_ROW2);
                    4'd5: step = mk(K_CMD, C_ER2);
                    4'd6: step = mk(K_WAIT, 4'd0);
                    4'd7: step = mk(K_CMD, C_ST);
                    4'd8: step = mk(K_DLY, 4'd0);
                    4'd9: step = mk(K_READ, 4'd0);
                    default: step = mk(K_END, 4'd0);
                endcase
            end
            OP_COL_RD: begin
                case (idx)
                    4'd0: step = mk(K_WAIT, 4'd0);
                    4'd1: step = mk(K_CMD, C_DO1);
                    4'd2: step = mk(K_ADDR, A_COL0);
                    4'd3: step = mk(K_ADDR, A_COL1);
                    4'd4: step = mk(K_CMD, C_DO2);
                    4'd5: step = mk(K_WAIT, 4'd0);
                    4'd6: step = mk(K_XFER, 4'd0);
                    default: step = mk(K_END, 4'd0);
                endcase
            end
            OP_STAT: begin
                case (idx)
                    4'd0: step = mk(K_WAIT, 4'd0);
                    4'd1: step = mk(K_CMD, C_ST);
                    4'd2: step = mk(K_DLY, 4'd0);
                    4'd3: step = mk(K_READ, 4'd0);
                    default: step = mk(K_END, 4'd0);
                endcase
            end
            OP_READ_ID: begin
                case (idx)
                    4'd0: step = mk(K_CMD, C_RST);
                    4'd1: step = mk(K_WAIT, 4'd0);
                    4'd2: step = mk(K_CMD, C_ID);
                    4'd3: step = mk(K_ADDR, A_ZERO);
                    4'd4: step = mk(K_DLY, 4'd1);
                    4'd5: step = mk(K_READ, 4'd1);
                    default: step = mk(K_END, 4'd0);
                endcase
            end
            OP_RESET: begin
                case (idx)
                    4'd0: step = mk(K_CMD, C_RST);
                    4'd1: step = mk(K_WAIT, 4'd0);
                    default: step = mk(K_END, 4'd0);
                endcase
            end
            default: step = mk(K_END, 4'd0);
        endcase
    end
endmodule

// File: rtl/nand_cmd_seq.sv
// NAND command sequencer top. It runs the step list of one request on
// the 8-bit flash bus, with one clock per latch strobe. Assumes the
// flash pulls rb_n low within WB_CYC-2 cycles of a confirm command.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int         ROW_W    = 24,
    parameter int         COL_W    = 16,
    parameter int         ID_BYTES = 8,
    parameter int         WB_CYC   = 4,
    parameter int         STAT_DLY = 16,
    parameter int         ID_DLY   = 40,
    parameter logic [7:0] CMD_RD1  = 8'h00,
    parameter logic [7:0] CMD_RD2  = 8'h30,
    parameter logic [7:0] CMD_PG1  = 8'h80,
    parameter logic [7:0] CMD_PG2  = 8'h10,
    parameter logic [7:0] CMD_ER1  = 8'h60,
    parameter logic [7:0] CMD_ER2  = 8'hD0,
    parameter logic [7:0] CMD_DO1  = 8'h05,
    parameter logic [7:0] CMD_DO2  = 8'hE0,
    parameter logic [7:0] CMD_ST   = 8'h70,
    parameter logic [7:0] CMD_ID   = 8'h90,
    parameter logic [7:0] CMD_RST  = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       io_out,
    output logic             io_oe,
    input  logic [7:0]       io_in,
    input  logic             rb_n,
    output logic             xfer_req,
    output logic             xfer_wr,
    input  logic             xfer_done
);
    localparam int MAXC = ((ID_DLY > STAT_DLY) ? ID_DLY : STAT_DLY) + WB_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam int RW   = $clog2(ID_BYTES) + 1;

    logic             busy_q, done_q, fail_q, rdv_q;
    logic [7:0]       rdd_q;
    logic [2:0]       op_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [3:0]       idx_q;
    logic [RW-1:0]    rcnt_q;
    logic [TW-1:0]    cnt;
    logic             rdy_s, adv;
    logic [23:0]      row_ext;
    logic [15:0]      col_ext;
    step_t            st;

    nand_rb_sync u_sync (.clk(clk), .rst_n(rst_n), .rb_n(rb_n), .rdy_s(rdy_s));

    nand_step_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(adv || !busy_q), .count(cnt)
    );

    nand_step_dec u_dec (.op(op_q), .idx(idx_q), .step(st));

    assign row_ext = 24'(row_q);
    assign col_ext = 16'(col_q);

    // decide whether the current step is complete this cycle
    always_comb begin
        adv = 1'b0;
        if (busy_q) begin
            case (st.kind)
                K_CMD, K_ADDR: adv = 1'b1;
                K_WAIT: adv = (cnt >= TW'(WB_CYC - 1)) && rdy_s;
                K_DLY:  adv = st.arg[0] ? (cnt >= TW'(ID_DLY - 1)) : (cnt >= TW'(STAT_DLY - 1));
                K_XFER: adv = xfer_done;
                K_READ: adv = !st.arg[0] || (rcnt_q == RW'(ID_BYTES - 1));
                default: adv = 1'b0;
            endcase
        end
    end

    // request acceptance, step progress and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            op_q   <= '0;
            row_q  <= '0;
            col_q  <= '0;
            idx_q  <= '0;
            rcnt_q <= '0;
        end else if (!busy_q) begin
            done_q <= 1'b0;
            if (req_valid) begin
                busy_q <= 1'b1;
                op_q   <= req_op;
                row_q  <= req_row;
                col_q  <= req_col;
                idx_q  <= '0;
                rcnt_q <= '0;
                fail_q <= 1'b0;
            end
        end else if (st.kind == K_END) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
        end else begin
            if (st.kind == K_READ && (op_q == OP_PAGE_PG || op_q == OP_BLK_ER))
                fail_q <= io_in[0];
            if (adv) begin
                idx_q  <= idx_q + 1'b1;
                rcnt_q <= '0;
            end else if (st.kind == K_READ) begin
                rcnt_q <= rcnt_q + 1'b1;
            end
        end
    end

    // capture each byte read from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdv_q <= 1'b0;
            rdd_q <= '0;
        end else begin
            rdv_q <= busy_q && (st.kind == K_READ);
            rdd_q <= io_in;
        end
    end

    // map the step to flash bus pins
    always_comb begin
        cle    = 1'b0;
        ale    = 1'b0;
        we_n   = 1'b1;
        re_n   = 1'b1;
        io_oe  = 1'b0;
        io_out = 8'h00;
        if (busy_q) begin
            case (st.kind)
                K_CMD: begin
                    cle = 1'b1; we_n = 1'b0; io_oe = 1'b1;
                    case (st.arg)
                        C_RD1: io_out = CMD_RD1;
                        C_RD2: io_out = CMD_RD2;
                        C_PG1: io_out = CMD_PG1;
                        C_PG2: io_out = CMD_PG2;
                        C_ER1: io_out = CMD_ER1;
                        C_ER2: io_out = CMD_ER2;
                        C_DO1: io_out = CMD_DO1;
                        C_DO2: io_out = CMD_DO2;
                        C_ST:  io_out = CMD_ST;
                        C_ID:  io_out = CMD_ID;
                        default: io_out = CMD_RST;
                    endcase
                end
                K_ADDR: begin
                    ale = 1'b1; we_n = 1'b0; io_oe = 1'b1;
                    case (st.arg)
                        A_COL0: io_out = col_ext[7:0];
                        A_COL1: io_out = col_ext[15:8];
                        A_ROW0: io_out = row_ext[7:0];
                        A_ROW1: io_out = row_ext[15:8];
                        A_ROW2: io_out = row_ext[23:16];
                        default: io_out = 8'h00;
                    endcase
                end
                K_READ: re_n = 1'b0;
                default: ;
            endcase
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign fail     = done_q & fail_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdd_q;
    assign ce_n     = ~busy_q;
    assign xfer_req = busy_q && (st.kind == K_XFER);
    assign xfer_wr  = st.arg[0];
endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Protocol checker for nand_cmd_seq, attached with bind.
module nand_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic fail,
    input logic rd_valid,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n,
    input logic xfer_req
);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
    // R11
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ce_n && we_n && re_n && !xfer_req));
    // R11
    one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!ce_n && $onehot0({cle, ale}) && (cle || ale) && re_n));
    // R7
    rd_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!re_n));
    // R9
    fail_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (.*);

// File: tb/sim_nand_cmd_seq.sv
`timescale 1ns/1ps
module sim_nand_cmd_seq;
    localparam int STAT_DLY = 16;
    localparam int ID_DLY   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [23:0] req_row = '0;
    logic [15:0] req_col = '0;
    logic busy, done, fail, rd_valid, ce_n, cle, ale, we_n, re_n, io_oe;
    logic xfer_req, xfer_wr;
    logic [7:0] rd_data, io_out, io_in;
    logic rb_n;
    logic xfer_done = 1'b0;

    always #2.5 clk = ~clk;

    nand_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_row(req_row), .req_col(req_col), .busy(busy), .done(done),
        .fail(fail), .rd_valid(rd_valid), .rd_data(rd_data), .ce_n(ce_n),
        .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out),
        .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n), .xfer_req(xfer_req),
        .xfer_wr(xfer_wr), .xfer_done(xfer_done)
    );

    int errors = 0;
    int checks = 0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] rd_bytes [8];
    logic [2:0] rd_ptr = '0;
    logic rd_clr = 1'b0;
    logic rb_model = 1'b1;
    logic hold_busy = 1'b0;
    int   bcnt = 0;
    int   busy_len = 10;
    int   xcnt = 0;

    assign io_in = rd_bytes[rd_ptr];
    assign rb_n  = rb_model & ~hold_busy;

    // advance the read pointer after each read strobe
    always @(posedge clk) begin
        if (rd_clr)     rd_ptr <= '0;
        else if (!re_n) rd_ptr <= rd_ptr + 3'd1;
    end

    // busy after confirm or reset commands
    always @(posedge clk) begin
        if (!we_n && cle && (io_out == 8'h30 || io_out == 8'h10 || io_out == 8'hD0 || io_out == 8'hFF)) begin
            rb_model <= 1'b0;
            bcnt <= busy_len;
        end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
            if (bcnt == 1) rb_model <= 1'b1;
        end
    end

    // data mover answers after three cycles
    always @(posedge clk) begin
        if (xfer_req && !xfer_done) begin
            xcnt <= xcnt + 1;
            if (xcnt == 2) begin xfer_done <= 1'b1; xcnt <= 0; end
        end else begin
            xfer_done <= 1'b0;
        end
    end

    // ---------------- scoreboard ----------------
    // event: {2'b10,cmd} {2'b01,addr} {2'b00,read byte} {2'b11,dir}
    logic [9:0] exp_q [$];
    int gap_q [$];
    int cyc = 0;
    int last_strobe = 0;
    logic re_prev = 1'b1;
    int strobes = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic observe(input logic [9:0] ev, input string req);
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, {req, " unexpected event"}, int'(ev), 0);
        end else begin
            e = exp_q.pop_front();
            check(ev == e, req, int'(ev), int'(e));
        end
    endtask

    // monitor bus activity between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) begin
                strobes++;
                last_strobe = cyc;
                observe({cle, ale, io_out}, "R3/R4/R5/R6/R8/R12 latch");
            end
            if (!re_n && re_prev) begin
                if (gap_q.size() == 0) check(1'b0, "R7/R8 read gap", cyc - last_strobe, 0);
                else begin
                    int g;
                    g = gap_q.pop_front();
                    check((cyc - last_strobe) == g, "R7/R8 read gap", cyc - last_strobe, g);
                end
            end
            if (rd_valid) observe({2'b00, rd_data}, "R7/R8 read byte");
            if (xfer_req && xfer_done) observe({2'b11, 7'b0, xfer_wr}, "R4/R6 transfer");
        end
        re_prev = re_n;
    end

    task automatic pc(input logic [7:0] b); exp_q.push_back({2'b10, b}); endtask
    task automatic pa(input logic [7:0] b); exp_q.push_back({2'b01, b}); endtask
    task automatic pr(input logic [7:0] b); exp_q.push_back({2'b00, b}); endtask
    task automatic px(input logic d);       exp_q.push_back({2'b11, 7'b0, d}); endtask

    // driver: push the expected events, then run the request
    task automatic run_op(input logic [2:0] op, input logic [23:0] row, input logic [15:0] col,
                          input logic [7:0] stat, input logic exp_fail, input logic poke,
                          input string req);
        int n;
        for (int k = 0; k < 8; k++) rd_bytes[k] = (op == 3'd5) ? (8'hA0 + 8'(k)) : stat;
        case (op)
            3'd0: begin pc(8'h00); pa(0); pa(0); pa(row[7:0]); pa(row[15:8]); pa(row[23:16]); pc(8'h30); end
            3'd1: begin pc(8'h80); pa(0); pa(0); pa(row[7:0]); pa(row[15:8]); pa(row[23:16]);
                        px(1'b1); pc(8'h10); pc(8'h70); pr(stat); gap_q.push_back(STAT_DLY + 1); end
            3'd2: begin pc(8'h60); pa(row[7:0]); pa(row[15:8]); pa(row[23:16]); pc(8'hD0);
                        pc(8'h70); pr(stat); gap_q.push_back(STAT_DLY + 1); end
            3'd3: begin pc(8'h05); pa(col[7:0]); pa(col[15:8]); pc(8'hE0); px(1'b0); end
            3'd4: begin pc(8'h70); pr(stat); gap_q.push_back(STAT_DLY + 1); end
            3'd5: begin pc(8'hFF); pc(8'h90); pa(0); gap_q.push_back(ID_DLY + 1);
                        for (int k = 0; k < 8; k++) pr(8'hA0 + 8'(k)); end
            default: pc(8'hFF);
        endcase
        @(negedge clk);
        rd_clr = 1'b1;
        req_valid = 1'b1; req_op = op; req_row = row; req_col = col;
        @(negedge clk);
        rd_clr = 1'b0;
        req_valid = 1'b0;
        check(busy == 1'b1, {req, " R1 busy after start"}, busy, 1);
        n = 0;
        while (!done && n < 3000) begin
            if (poke && n == 3) begin
                req_valid = 1'b1; req_op = 3'd2; req_row = 24'hFFFFFF;
            end else req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        check(done == 1'b1, {req, " R1 done seen"}, done, 1);
        check(busy == 1'b0, {req, " R1 busy low with done"}, busy, 0);
        check(fail == exp_fail, {req, " R9 fail flag"}, fail, exp_fail);
        @(negedge clk);
        check(done == 1'b0, {req, " R1 done one cycle"}, done, 0);
        repeat (4) @(negedge clk);
        check(done == 1'b0, {req, " R2 no extra done"}, done, 0);
        check(exp_q.size() == 0, {req, " events left"}, exp_q.size(), 0);
        check(gap_q.size() == 0, {req, " read gaps left"}, gap_q.size(), 0);
        exp_q.delete();
        gap_q.delete();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        for (int k = 0; k < 8; k++) rd_bytes[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !fail && !rd_valid, "R1 reset outputs", {busy, done, fail, rd_valid}, 0);
        check(ce_n && we_n && re_n, "R11 idle bus after reset", {ce_n, we_n, re_n}, 3'b111);

        run_op(3'd6, 24'h0, 16'h0, 8'h00, 1'b0, 1'b0, "R12 reset");
        run_op(3'd0, 24'h123456, 16'h0, 8'h00, 1'b0, 1'b0, "R3 page read");
        run_op(3'd0, 24'hFEDCBA, 16'h0, 8'h00, 1'b0, 1'b1, "R2 page read with poke");
        run_op(3'd1, 24'h00A5C3, 16'h0, 8'hE0, 1'b0, 1'b0, "R4 program pass");
        run_op(3'd1, 24'h7F0001, 16'h0, 8'hE1, 1'b1, 1'b0, "R4 program fail");
        run_op(3'd2, 24'h0400C0, 16'h0, 8'hC1, 1'b1, 1'b0, "R5 erase fail");
        run_op(3'd2, 24'h000040, 16'h0, 8'hC0, 1'b0, 1'b0, "R5 erase pass");
        run_op(3'd3, 24'h0, 16'h0834, 8'h00, 1'b0, 1'b0, "R6 random data-out");
        run_op(3'd4, 24'h0, 16'h0, 8'h81, 1'b0, 1'b0, "R7 status, R9 no fail");
        run_op(3'd5, 24'h0, 16'h0, 8'h00, 1'b0, 1'b0, "R8 read id");

        // R10: ready held low blocks the first latch cycle
        hold_busy = 1'b1;
        busy_len = 30;
        s0 = strobes;
        pc(8'h70); pr(8'h5A); gap_q.push_back(STAT_DLY + 1);
        rd_bytes[0] = 8'h5A;
        @(negedge clk);
        rd_clr = 1'b1; req_valid = 1'b1; req_op = 3'd4;
        @(negedge clk);
        rd_clr = 1'b0; req_valid = 1'b0;
        repeat (40) @(negedge clk);
        check(strobes == s0, "R10 no latch while not ready", strobes - s0, 0);
        check(busy == 1'b1, "R10 still waiting", busy, 1);
        hold_busy = 1'b0;
        repeat (60) @(negedge clk);
        check(strobes == s0 + 1, "R10 proceeds after ready", strobes - s0, 1);
        check(exp_q.size() == 0, "R10 events left", exp_q.size(), 0);
        exp_q.delete(); gap_q.delete();

        // R10: long busy after confirm with erase
        run_op(3'd2, 24'h112233, 16'h0, 8'h00, 1'b0, 1'b0, "R10 erase long busy");
        check(ce_n && we_n && re_n, "R11 idle bus at end", {ce_n, we_n, re_n}, 3'b111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule